// File: doc/BRIEF.md
# Event Injection and Spy Buffer

This block sits at the input and output of one processing unit in a pipelined trigger datapath and serves as a debug aid. On the input side it can replace the live link word that feeds the processing core with event words loaded in advance, presenting one stored entry per clock. A replay begins on a synchronisation pulse, so every unit in a system starts on entry 0 in the same cycle. The replay then either runs once through the whole memory or loops over it without end.

On the output side it can capture a window of consecutive valid results from the processing core. Once the window is captured it is frozen and a slow control host reads it back. While spy mode is on, results are withheld from the acquisition path. Loading, arming, clearing and reading all go through a 16-bit register-style host bus. Each wide event word is moved as successive 16-bit slices, low slice first, through an address that steps forward by itself.

Top module: `evt_inject_spy`

## Requirements
- R1: After reset, `core_data_o` equals `link_data_i`, `daq_valid_o` equals `proc_valid_i`, and the status word at host address 0 reads 0.
- R2: A host write to address 1 sets the injection entry index. Each access to address 2 transfers one 16-bit slice of that entry, low slice first. A write on the last slice stores the assembled word. After the last slice the index advances, wrapping from INJ_DEPTH-1 to 0. Reads through address 2 return the stored slices in the same order.
- R3: With inject enable (control bit 0) set, a `sync_i` pulse starts a replay. On the k-th cycle after the pulse, `core_data_o` equals stored entry k.
- R4: A `sync_i` pulse while inject enable is clear has no effect: `core_data_o` stays on `link_data_i` and the active status bit (bit 4) stays 0.
- R5: With circular mode (control bit 1) clear, the replay stops after entry INJ_DEPTH-1. `core_data_o` then returns to `link_data_i`, and status bit 5 (done) is set until the next start.
- R6: With circular mode set, entry INJ_DEPTH-1 is followed by entry 0 and the replay continues without end.
- R7: Clearing inject enable ends a replay. By the second clock edge after the write, `core_data_o` follows `link_data_i` again.
- R8: A control write with spy enable (bit 2) and arm (bit 3) both set arms capture. Capture begins with the cycle after the write and stores `proc_data_i` of the next SPY_DEPTH cycles on which `proc_valid_i` is high. Cycles with `proc_valid_i` low are skipped.
- R9: After SPY_DEPTH captured events, status bit 7 (full) is set and bit 6 (armed) is clear. Later events leave the stored data unchanged. A control write with bit 4 set clears the full flag and keeps the data.
- R10: While spy enable is set, `daq_valid_o` is 0. Otherwise `daq_valid_o` follows `proc_valid_i`. `daq_data_o` always follows `proc_data_i`.
- R11: A host write to address 3 sets the spy entry index. Reads of address 4 return that entry's 16-bit slices, low slice first, and the index advances after the last slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Replay start pulse |
| link_data_i | input | EVW | Live link event word |
| core_data_o | output | EVW | Event word presented to the processing core |
| proc_data_i | input | EVW | Processing core result word |
| proc_valid_i | input | 1 | Result valid (event boundary) |
| daq_data_o | output | EVW | Result forwarded to acquisition |
| daq_valid_o | output | 1 | Acquisition valid, held low in spy mode |
| hst_sel_i | input | 1 | Host access strobe |
| hst_wr_i | input | 1 | Host write (1) or read (0) |
| hst_addr_i | input | 3 | Host register address |
| hst_wdata_i | input | 16 | Host write data |
| hst_rdata_o | output | 16 | Host read data |

## Verification
If the replay pointer is off by one or misses its wrap, `core_data_o` departs from the expected entry on the very next cycle. A scoreboard compares every replayed word, so such a fault is seen at once. If the single-shot stop or the done flag is wrong, the error shows in the cycle after the last entry or in the next status read. Faults in the capture window, such as an off-by-one start, counting invalid cycles or overwriting after full, show only when the host reads the frozen entries back. For that reason the bench feeds capture with gapped valid cycles and one event beyond the window.

// File: rtl/evt_inject_spy.sv
`timescale 1ns/1ps
module evt_inject_spy #(
  parameter int EVW       = 32,
  parameter int INJ_DEPTH = 3563,
  parameter int SPY_DEPTH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sync_i,
  input  logic [EVW-1:0] link_data_i,
  output logic [EVW-1:0] core_data_o,
  input  logic [EVW-1:0] proc_data_i,
  input  logic           proc_valid_i,
  output logic [EVW-1:0] daq_data_o,
  output logic           daq_valid_o,
  input  logic           hst_sel_i,
  input  logic           hst_wr_i,
  input  logic [2:0]     hst_addr_i,
  input  logic [15:0]    hst_wdata_i,
  output logic [15:0]    hst_rdata_o
);
  localparam int NSL = (EVW + 15) / 16;
  localparam int SLW = (NSL > 1) ? $clog2(NSL) : 1;
  localparam int IAW = $clog2(INJ_DEPTH);
  localparam int SAW = (SPY_DEPTH > 1) ? $clog2(SPY_DEPTH) : 1;
  localparam int WW  = NSL * 16;
  localparam logic [IAW-1:0] I_LAST  = IAW'(INJ_DEPTH - 1);
  localparam logic [SAW-1:0] S_LAST  = SAW'(SPY_DEPTH - 1);
  localparam logic [SLW-1:0] SL_LAST = SLW'(NSL - 1);
  localparam logic [2:0] A_CTRL = 3'd0, A_IPTR = 3'd1, A_IDAT = 3'd2,
                         A_SPTR = 3'd3, A_SDAT = 3'd4;

  logic [EVW-1:0] inj_mem [INJ_DEPTH];
  logic [EVW-1:0] spy_mem [SPY_DEPTH];

  logic           inj_en, circ, spy_en, active, done, armed, full;
  logic [IAW-1:0] rp, ia;
  logic [SAW-1:0] sa, sc;
  logic [SLW-1:0] is_q, ss_q;
  logic [WW-1:0]  stage, merged, irow, srow;

  wire hw       = hst_sel_i & hst_wr_i;
  wire hr       = hst_sel_i & ~hst_wr_i;
  wire wr_ctrl  = hw && (hst_addr_i == A_CTRL);
  wire idat_acc = hst_sel_i && (hst_addr_i == A_IDAT);
  wire sdat_rd  = hr && (hst_addr_i == A_SDAT);
  wire commit   = hw && (hst_addr_i == A_IDAT) && (is_q == SL_LAST);
  wire arm      = wr_ctrl & hst_wdata_i[2] & hst_wdata_i[3];
  wire capture  = armed & proc_valid_i;

  function automatic logic [IAW-1:0] inext(input logic [IAW-1:0] a);
    return (a == I_LAST) ? '0 : a + 1'b1;
  endfunction

  always_comb begin
    merged = stage;
    merged[is_q*16 +: 16] = hst_wdata_i;
  end

  assign irow        = WW'(inj_mem[ia]);
  assign srow        = WW'(spy_mem[sa]);
  assign core_data_o = active ? inj_mem[rp] : link_data_i;
  assign daq_data_o  = proc_data_i;
  assign daq_valid_o = proc_valid_i & ~spy_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inj_en <= 1'b0; circ <= 1'b0; spy_en <= 1'b0;
      ia <= '0; is_q <= '0; sa <= '0; ss_q <= '0; stage <= '0;
    end else begin
      if (wr_ctrl) {spy_en, circ, inj_en} <= hst_wdata_i[2:0];
      if (hw && hst_addr_i == A_IPTR) begin
        ia   <= (hst_wdata_i < 16'(INJ_DEPTH)) ? IAW'(hst_wdata_i) : '0;
        is_q <= '0;
      end else if (idat_acc) begin
        if (hst_wr_i) stage <= merged;
        if (is_q == SL_LAST) begin
          is_q <= '0;
          ia   <= inext(ia);
        end else begin
          is_q <= is_q + 1'b1;
        end
      end
      if (hw && hst_addr_i == A_SPTR) begin
        sa   <= SAW'(hst_wdata_i);
        ss_q <= '0;
      end else if (sdat_rd) begin
        if (ss_q == SL_LAST) begin
          ss_q <= '0;
          sa   <= (sa == S_LAST) ? '0 : sa + 1'b1;
        end else begin
          ss_q <= ss_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit)  inj_mem[ia] <= merged[EVW-1:0];
    if (capture) spy_mem[sc] <= proc_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; done <= 1'b0; rp <= '0;
    end else if (sync_i && inj_en) begin
      active <= 1'b1; done <= 1'b0; rp <= '0;
    end else if (!inj_en) begin
      active <= 1'b0;
    end else if (active) begin
      if (rp == I_LAST) begin
        rp <= '0;
        if (!circ) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end else begin
        rp <= rp + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; full <= 1'b0; sc <= '0;
    end else if (arm) begin
      armed <= 1'b1; full <= 1'b0; sc <= '0;
    end else begin
      if (capture) begin
        sc <= (sc == S_LAST) ? '0 : sc + 1'b1;
        if (sc == S_LAST) begin
          armed <= 1'b0;
          full  <= 1'b1;
        end
      end
      if (wr_ctrl && hst_wdata_i[4]) full  <= 1'b0;
      if (wr_ctrl && !hst_wdata_i[2]) armed <= 1'b0;
    end
  end

  always_comb begin
    case (hst_addr_i)
      A_CTRL:  hst_rdata_o = {8'h00, full, armed, done, active, 1'b0, spy_en, circ, inj_en};
      A_IPTR:  hst_rdata_o = 16'(ia);
      A_IDAT:  hst_rdata_o = irow[is_q*16 +: 16];
      A_SPTR:  hst_rdata_o = 16'(sa);
      A_SDAT:  hst_rdata_o = srow[ss_q*16 +: 16];
      default: hst_rdata_o = 16'h0000;
    endcase
  end
endmodule

// File: rtl/evt_inject_spy_chk.sv
`timescale 1ns/1ps
module evt_inject_spy_chk #(
  parameter int EVW       = 32,
  parameter int INJ_DEPTH = 3563,
  parameter int SPY_DEPTH = 16,
  parameter int IAW       = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sync_i,
  input logic           inj_en,
  input logic           circ,
  input logic           spy_en,
  input logic           active,
  input logic           done,
  input logic           armed,
  input logic           full,
  input logic [IAW-1:0] rp,
  input logic           proc_valid_i,
  input logic           daq_valid_o,
  input logic           hst_sel_i,
  input logic           hst_wr_i,
  input logic [2:0]     hst_addr_i
);
  localparam logic [IAW-1:0] LAST = IAW'(INJ_DEPTH - 1);
  wire ctrl_wr = hst_sel_i & hst_wr_i & (hst_addr_i == 3'd0);

  AST_SYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i && inj_en |=> active && rp == '0); // R3
  AST_REPLAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    active && $past(active) && rp != '0 |-> rp == $past(rp) + 1'b1); // R3
  AST_SYNC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !inj_en |=> !active); // R4
  AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    active && inj_en && !circ && !sync_i && rp == LAST |=> !active && done); // R5
  AST_CIRC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    active && inj_en && circ && !sync_i && rp == LAST |=> active && rp == '0); // R6
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rp <= LAST); // R3
  AST_FULL_NOT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !armed); // R9
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    full && !ctrl_wr |=> full); // R9
  AST_DAQ_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    spy_en && proc_valid_i |-> !daq_valid_o); // R10
endmodule

bind evt_inject_spy evt_inject_spy_chk #(
  .EVW(EVW), .INJ_DEPTH(INJ_DEPTH), .SPY_DEPTH(SPY_DEPTH), .IAW(IAW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .inj_en(inj_en), .circ(circ),
  .spy_en(spy_en), .active(active), .done(done), .armed(armed), .full(full),
  .rp(rp), .proc_valid_i(proc_valid_i), .daq_valid_o(daq_valid_o),
  .hst_sel_i(hst_sel_i), .hst_wr_i(hst_wr_i), .hst_addr_i(hst_addr_i)
);

// File: tb/evt_inject_spy_tb_top.sv
`timescale 1ns/1ps
module evt_inject_spy_tb_top;
  localparam int DEPTH = 3563;
  localparam int SPYD  = 16;
  localparam logic [31:0] LINK = 32'h1EAF_0F0F;

  logic        clk = 1'b0;
  logic        rst_n, sync_i, proc_valid_i, hst_sel_i, hst_wr_i;
  logic [31:0] link_data_i, core_data_o, proc_data_i, daq_data_o;
  logic        daq_valid_o;
  logic [2:0]  hst_addr_i;
  logic [15:0] hst_wdata_i, hst_rdata_o;

  int nchk = 0, nerr = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          mon_on = 1'b0;

  always #10 clk = ~clk;

  evt_inject_spy #(.EVW(32), .INJ_DEPTH(DEPTH), .SPY_DEPTH(SPYD)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .link_data_i(link_data_i),
    .core_data_o(core_data_o), .proc_data_i(proc_data_i),
    .proc_valid_i(proc_valid_i), .daq_data_o(daq_data_o),
    .daq_valid_o(daq_valid_o), .hst_sel_i(hst_sel_i), .hst_wr_i(hst_wr_i),
    .hst_addr_i(hst_addr_i), .hst_wdata_i(hst_wdata_i), .hst_rdata_o(hst_rdata_o));

  function automatic logic [31:0] pat(int i);
    return {16'(i * 7 + 3) ^ 16'h5A00, 16'(i)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    hst_sel_i = 1'b1; hst_wr_i = 1'b1; hst_addr_i = a; hst_wdata_i = d;
    @(negedge clk);
    hst_sel_i = 1'b0; hst_wr_i = 1'b0;
  endtask

  task automatic hread(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    hst_sel_i = 1'b1; hst_wr_i = 1'b0; hst_addr_i = a;
    #5 d = hst_rdata_o;
    @(negedge clk);
    hst_sel_i = 1'b0;
  endtask

  // monitor: pops one expected core word per cycle while enabled
  initial forever begin
    @(negedge clk);
    #5;
    if (mon_on && exp_q.size() > 0) check(tag_q.pop_front(), core_data_o, exp_q.pop_front());
  end

  // driver: fills the scoreboard, then fires the sync pulse
  task automatic run_inj(bit circular, int extra);
    for (int i = 0; i < DEPTH; i++) begin exp_q.push_back(pat(i)); tag_q.push_back("R3"); end
    for (int j = 0; j < extra; j++) begin
      if (circular) begin exp_q.push_back(pat(j)); tag_q.push_back("R6"); end
      else begin exp_q.push_back(LINK); tag_q.push_back("R5"); end
    end
    @(negedge clk); sync_i = 1'b1;
    @(negedge clk); sync_i = 1'b0; mon_on = 1'b1;
    wait (exp_q.size() == 0);
    mon_on = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog (all R) act=timeout exp=completion");
    finish_run();
  end

  initial begin
    logic [15:0] rd, lo, hi;
    logic [31:0] sexp [SPYD];
    int          ns;
    rst_n = 1'b0; sync_i = 1'b0; proc_valid_i = 1'b0; proc_data_i = '0;
    hst_sel_i = 1'b0; hst_wr_i = 1'b0; hst_addr_i = '0; hst_wdata_i = '0;
    link_data_i = LINK;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #5;
    check("R1 core", core_data_o, LINK);
    check("R1 daq_valid", 32'(daq_valid_o), 32'd0);
    hread(3'd0, rd); check("R1 status", 32'(rd), 32'h0);

    @(negedge clk); proc_valid_i = 1'b1; proc_data_i = 32'h1234_5678; #5;
    check("R10 daq_valid pass", 32'(daq_valid_o), 32'd1);
    check("R10 daq_data", daq_data_o, 32'h1234_5678);
    @(negedge clk); proc_valid_i = 1'b0;

    // R4: sync without inject enable
    sync_i = 1'b1; @(negedge clk); sync_i = 1'b0; #5;
    check("R4 core", core_data_o, LINK);
    hread(3'd0, rd); check("R4 active", 32'(rd[4]), 32'd0);

    // R2: load and read back
    hwrite(3'd1, 16'd0);
    for (int i = 0; i < DEPTH; i++) begin
      hwrite(3'd2, pat(i)[15:0]);
      hwrite(3'd2, pat(i)[31:16]);
    end
    hwrite(3'd1, 16'(DEPTH - 2));
    for (int k = 0; k < 3; k++) begin
      hread(3'd2, lo); hread(3'd2, hi);
      check("R2 readback", {hi, lo}, pat((DEPTH - 2 + k) % DEPTH));
    end

    // R3/R5: single shot
    hwrite(3'd0, 16'h0001);
    run_inj(1'b0, 3);
    hread(3'd0, rd); check("R5 status done", 32'(rd), 32'h0021);

    // R6/R7: circular then stop
    hwrite(3'd0, 16'h0003);
    run_inj(1'b1, 5);
    hwrite(3'd0, 16'h0002);
    @(negedge clk); #5;
    check("R7 core back to link", core_data_o, LINK);
    hread(3'd0, rd); check("R7 status", 32'(rd), 32'h0002);

    // R10: suppression in spy mode
    hwrite(3'd0, 16'h0004);
    @(negedge clk); proc_valid_i = 1'b1; proc_data_i = 32'hAAAA_5555; #5;
    check("R10 daq suppressed", 32'(daq_valid_o), 32'd0);
    check("R10 daq_data spy", daq_data_o, 32'hAAAA_5555);

    // R8: arm; word present in the arm cycle must not be captured
    proc_data_i = 32'hBAD0_BAD0;
    hwrite(3'd0, 16'h000C);
    ns = 0;
    for (int e = 0; e < 22; e++) begin
      proc_valid_i = (e % 4 != 2);
      proc_data_i  = 32'hC0DE_0000 + 32'(e);
      if (proc_valid_i && ns < SPYD) begin sexp[ns] = proc_data_i; ns++; end
      @(negedge clk);
    end
    proc_valid_i = 1'b0;
    hread(3'd0, rd); check("R9 full status", 32'(rd), 32'h0084);

    hwrite(3'd3, 16'd0);
    for (int k = 0; k < SPYD; k++) begin
      hread(3'd4, lo); hread(3'd4, hi);
      check((k == SPYD - 1) ? "R9 hold last" : "R8 R11 spy entry", {hi, lo}, sexp[k]);
    end

    hwrite(3'd0, 16'h0014);
    hread(3'd0, rd); check("R9 cleared", 32'(rd), 32'h0004);
    hwrite(3'd3, 16'd0);
    hread(3'd4, lo); hread(3'd4, hi);
    check("R9 data kept", {hi, lo}, sexp[0]);

    hwrite(3'd0, 16'h0000);
    @(negedge clk); proc_valid_i = 1'b1; #5;
    check("R10 daq resumes", 32'(daq_valid_o), 32'd1);
    @(negedge clk); proc_valid_i = 1'b0;

    finish_run();
  end
endmodule